// File: doc/BRIEF.md
# Legacy Interrupt Aggregator

This block gathers eighteen external interrupt request lines into one active-high, level-sensitive interrupt for a parent controller. Each line is first brought into the local clock domain by a two-stage synchroniser. It can then be inverted by a per-line polarity bit. After that it is either followed as a level or caught on its rising edge. The result lands in a status vector, which is masked per line and gated by a global enable to form the combined request.

Software drives it through a simple 32-bit register port. The port has a write strobe, a read strobe and a word address. Software programs the control word, the line mask and the polarity vector, and reads them back unchanged. It reads the status vector and acknowledges latched edges by writing ones to an acknowledge word. A driver finds the lines that need service by ANDing the mask and status words it reads. A typical start-up sequence sets the global enable, writes zero to the mask, and acknowledges all eighteen lines.

Top module: `irq_aggregator`

## Requirements
- R1: Registers sit at word addresses 0 (control), 1 (line mask), 2 (status, read-only), 3 (acknowledge, write-only, reads 0) and 4 (polarity). These correspond to byte offsets 0x00, 0x04, 0x08, 0x0C and 0x10.
- R2: Control bit 31 is the global enable and bit 30 selects edge capture when 1 and level following when 0. Control reads back those two bits as written, and all its other bits read 0.
- R3: The line mask reads back the last value written to bits 17:0, and bits 31:18 read 0. A 1 unmasks the line.
- R4: A polarity bit of 1 makes its line active-low and a 0 makes it active-high. The change reaches status one clock after the write. Polarity reads back in bits 17:0, and bits 31:18 read 0.
- R5: In level mode a status bit equals the polarity-corrected line. A change on the input pin shows up in status on the third rising clock edge after it.
- R6: In edge mode a status bit becomes 1 on the third clock edge after a 0-to-1 change of the corrected line. It stays 1 until it is acknowledged, even while the line stays high.
- R7: In edge mode, writing 1 to bit n of the acknowledge word clears status bit n at that write's clock edge. Bits written as 0 leave status unchanged.
- R8: When a new edge and an acknowledge of the same bit meet on one clock edge, the status bit ends up 1.
- R9: irq_out is 1 exactly when the global enable is 1 and status AND mask is nonzero.
- R10: Reads of word addresses 5 to 7 return 0, and writes to the status address have no effect.
- R11: After reset, control, mask, polarity and status read 0 and irq_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when no read is strobed |
| irq_src | input | 18 | Asynchronous interrupt request lines |
| irq_out | output | 1 | Combined active-high level request to the parent |

## Verification
Lines are driven with steady levels, with short two-cycle pulses, and with a line held high across an acknowledge. The steady levels tell level following apart from edge capture. The pulses show that a latched edge outlives its source. The held line shows that edge mode does not re-arm without a new transition. An active-low polarity with the pin at rest checks that inversion happens before capture. An acknowledge timed to land on the same edge as a fresh rise separates set-wins from clear-wins. A reference model tracks the combined output on every cycle while the mask and global enable are switched, so a wrong gating term shows up at once.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    localparam int NUM_SRC  = 18;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 3;
    localparam int BIT_GEN  = 31;
    localparam int BIT_EDGE = 30;

    typedef enum logic [2:0] {
        SEL_CTRL = 3'd0,
        SEL_MASK = 3'd1,
        SEL_STAT = 3'd2,
        SEL_ACK  = 3'd3,
        SEL_POL  = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic glob_en;
        logic edge_mode;
    } ctrl_t;

    function automatic logic [DATA_W-1:0] pack_ctrl(ctrl_t c);
        logic [DATA_W-1:0] v;
        v = '0;
        v[BIT_GEN]  = c.glob_en;
        v[BIT_EDGE] = c.edge_mode;
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] widen_src(logic [NUM_SRC-1:0] s);
        return {{(DATA_W-NUM_SRC){1'b0}}, s};
    endfunction

endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
    parameter int W      = 18,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stq;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) stq <= '0;
                else     stq <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stq <= '0;
                else     stq <= {stq[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = stq[STAGES-1];
endmodule

// File: rtl/irqagg_capture.sv
module irqagg_capture #(
    parameter int N = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] line_sync,
    input  logic [N-1:0] pol,
    input  logic         edge_mode,
    input  logic [N-1:0] ack,
    output logic [N-1:0] status
);
    logic [N-1:0] corr;
    logic [N-1:0] prev;
    logic [N-1:0] rise;

    assign corr = line_sync ^ pol;
    assign rise = corr & ~prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev   <= '0;
            status <= '0;
        end else begin
            prev <= corr;
            if (edge_mode) status <= (status & ~ack) | rise;
            else           status <= corr;
        end
    end

    // R5: level mode tracks corrected line one edge later
    p_level_track_r5: assert property (@(posedge clk) disable iff (rst)
        !edge_mode |=> status == $past(line_sync ^ pol));

    // R6: latched bits without acknowledge are kept
    p_edge_hold_r6: assert property (@(posedge clk) disable iff (rst)
        edge_mode |=> ((status & $past(status & ~ack)) == $past(status & ~ack)));

    // R7: acknowledged bits with no new edge go to zero
    p_ack_clear_r7: assert property (@(posedge clk) disable iff (rst)
        edge_mode |=> ((status & $past(ack & ~rise)) == '0));

    // R8: a new edge always lands, even against an acknowledge
    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        edge_mode |=> ((status & $past(rise)) == $past(rise)));
endmodule

// File: rtl/irqagg_regs.sv
module irqagg_regs
    import irqagg_pkg::*;
#(
    parameter int N  = NUM_SRC,
    parameter int AW = ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [N-1:0]      status,
    output logic [DATA_W-1:0] rdata,
    output ctrl_t             ctrl,
    output logic [N-1:0]      mask,
    output logic [N-1:0]      pol,
    output logic [N-1:0]      ack
);
    localparam logic [AW-1:0] A_CTRL = AW'(SEL_CTRL);
    localparam logic [AW-1:0] A_MASK = AW'(SEL_MASK);
    localparam logic [AW-1:0] A_STAT = AW'(SEL_STAT);
    localparam logic [AW-1:0] A_ACK  = AW'(SEL_ACK);
    localparam logic [AW-1:0] A_POL  = AW'(SEL_POL);

    logic unused_wbits;
    assign unused_wbits = ^wdata[BIT_EDGE-1:N];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            mask <= '0;
            pol  <= '0;
        end else if (wr) begin
            if (addr == A_CTRL) begin
                ctrl.glob_en   <= wdata[BIT_GEN];
                ctrl.edge_mode <= wdata[BIT_EDGE];
            end
            if (addr == A_MASK) mask <= wdata[N-1:0];
            if (addr == A_POL)  pol  <= wdata[N-1:0];
        end
    end

    assign ack = (wr && addr == A_ACK) ? wdata[N-1:0] : '0;

    always_comb begin
        rdata = '0;
        if (rd) begin
            unique case (addr)
                A_CTRL:  rdata = pack_ctrl(ctrl);
                A_MASK:  rdata = {{(DATA_W-N){1'b0}}, mask};
                A_STAT:  rdata = {{(DATA_W-N){1'b0}}, status};
                A_POL:   rdata = {{(DATA_W-N){1'b0}}, pol};
                default: rdata = '0;
            endcase
        end
    end

    // R3: mask holds the written value
    p_mask_write_r3: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == A_MASK) |=> mask == $past(wdata[N-1:0]));

    // R10: unmapped reads return zero
    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (rd && addr > A_POL) |-> rdata == '0);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irqagg_pkg::*;
#(
    parameter int N_SRC   = NUM_SRC,
    parameter int AW      = ADDR_W,
    parameter int SYNC_ST = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_SRC-1:0]  irq_src,
    output logic              irq_out
);
    logic [N_SRC-1:0] line_sync;
    logic [N_SRC-1:0] status;
    logic [N_SRC-1:0] mask;
    logic [N_SRC-1:0] pol;
    logic [N_SRC-1:0] ack;
    ctrl_t            ctrl;

    irqagg_sync #(.W(N_SRC), .STAGES(SYNC_ST)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (irq_src),
        .q   (line_sync)
    );

    irqagg_regs #(.N(N_SRC), .AW(AW)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (bus_wr),
        .rd     (bus_rd),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .status (status),
        .rdata  (bus_rdata),
        .ctrl   (ctrl),
        .mask   (mask),
        .pol    (pol),
        .ack    (ack)
    );

    irqagg_capture #(.N(N_SRC)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .line_sync (line_sync),
        .pol       (pol),
        .edge_mode (ctrl.edge_mode),
        .ack       (ack),
        .status    (status)
    );

    assign irq_out = ctrl.glob_en & (|(status & mask));

    // R9: no request while globally disabled
    p_gate_off_r9: assert property (@(posedge clk) disable iff (rst)
        !ctrl.glob_en |-> !irq_out);

    // R9: no request while every line is masked
    p_masked_off_r9: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> !irq_out);
endmodule

// File: tb/tb_irq_aggregator.sv
`timescale 1ns/1ps
module tb_irq_aggregator;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [17:0] irq_src = '0;
    logic        irq_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_aggregator dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_src(irq_src), .irq_out(irq_out)
    );

    // behavioural reference model for the combined request
    bit          m_en, m_edge;
    logic [17:0] m_mask, m_pol, m_sts, m_prev;
    logic [17:0] m_pipe[$];

    always @(posedge clk) begin
        logic [17:0] cur, rise, clr;
        if (rst) begin
            m_en = 0; m_edge = 0; m_mask = '0; m_pol = '0;
            m_sts = '0; m_prev = '0;
            m_pipe = '{18'd0, 18'd0};
        end else begin
            cur  = m_pipe[0] ^ m_pol;
            rise = cur & ~m_prev;
            clr  = (bus_wr && bus_addr == 3'd3) ? bus_wdata[17:0] : '0;
            if (m_edge) m_sts = (m_sts & ~clr) | rise;
            else        m_sts = cur;
            m_prev = cur;
            void'(m_pipe.pop_front());
            m_pipe.push_back(irq_src);
            if (bus_wr) begin
                case (bus_addr)
                    3'd0: begin m_en = bus_wdata[31]; m_edge = bus_wdata[30]; end
                    3'd1: m_mask = bus_wdata[17:0];
                    3'd4: m_pol  = bus_wdata[17:0];
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            n_chk++;
            if (irq_out !== (m_en && |(m_sts & m_mask))) begin
                n_fail++;
                $display("FAIL R9 model: irq_out=%0b expected=%0b at %0t",
                         irq_out, (m_en && |(m_sts & m_mask)), $time);
            end
        end
    end

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got=%08h expected=%08h", tag, got, exp);
        end
    endtask

    // called at a negedge; the write lands on the next posedge
    task automatic wr_reg(logic [2:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(string tag, logic [2:0] a, logic [31:0] exp);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
        bus_rd = 1'b0;
    endtask

    task automatic out_chk(string tag, logic exp);
        #1;
        chk(tag, {31'd0, irq_out}, {31'd0, exp});
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: got=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        rd_chk("R11 ctrl", 3'd0, 32'h0);
        rd_chk("R11 mask", 3'd1, 32'h0);
        rd_chk("R11 stat", 3'd2, 32'h0);
        rd_chk("R11 pol",  3'd4, 32'h0);
        out_chk("R11 irq_out", 1'b0);

        // R2 control fields
        wr_reg(3'd0, 32'hFFFF_FFFF);
        rd_chk("R2 ctrl bits", 3'd0, 32'hC000_0000);
        wr_reg(3'd0, 32'h8000_0000);
        rd_chk("R2 ctrl level", 3'd0, 32'h8000_0000);

        // R3 mask width, R1 ack reads zero
        wr_reg(3'd1, 32'hFFFF_FFFF);
        rd_chk("R3 mask", 3'd1, 32'h0003_FFFF);
        rd_chk("R1 ack reads 0", 3'd3, 32'h0);

        // R5 level following with latency
        irq_src = 18'h00005;
        repeat (2) @(negedge clk);
        rd_chk("R5 not yet", 3'd2, 32'h0);
        @(negedge clk);
        rd_chk("R5 level", 3'd2, 32'h5);
        out_chk("R9 asserted", 1'b1);

        // R9 masking and global enable
        wr_reg(3'd1, 32'h0000_0004);
        out_chk("R9 one unmasked", 1'b1);
        wr_reg(3'd1, 32'h0000_0002);
        out_chk("R9 masked", 1'b0);
        wr_reg(3'd1, 32'h0003_FFFF);
        wr_reg(3'd0, 32'h0000_0000);
        out_chk("R9 global off", 1'b0);
        wr_reg(3'd0, 32'h8000_0000);

        // R10 status write ignored, unmapped reads
        wr_reg(3'd2, 32'h0000_0000);
        rd_chk("R10 stat write ignored", 3'd2, 32'h5);
        rd_chk("R10 addr5", 3'd5, 32'h0);
        rd_chk("R10 addr7", 3'd7, 32'h0);

        irq_src = '0;
        repeat (3) @(negedge clk);
        rd_chk("R5 level low", 3'd2, 32'h0);

        // R4 polarity
        wr_reg(3'd4, 32'hFFFC_0011);
        rd_chk("R4 pol", 3'd4, 32'h0000_0011);
        @(negedge clk);
        rd_chk("R4 active-low idle", 3'd2, 32'h11);
        irq_src = 18'h00001;
        repeat (3) @(negedge clk);
        rd_chk("R4 driven pin", 3'd2, 32'h10);
        wr_reg(3'd4, 32'h0);
        irq_src = '0;
        repeat (4) @(negedge clk);
        rd_chk("R4 restored", 3'd2, 32'h0);

        // R6 edge capture of a short pulse
        wr_reg(3'd0, 32'hC000_0000);
        irq_src = 18'h00008;
        repeat (2) @(negedge clk);
        irq_src = '0;
        repeat (4) @(negedge clk);
        rd_chk("R6 latched", 3'd2, 32'h8);

        // R7 acknowledge
        wr_reg(3'd3, 32'h0);
        rd_chk("R7 zero ack", 3'd2, 32'h8);
        wr_reg(3'd3, 32'hFFFF_FFF7);
        rd_chk("R7 other bits", 3'd2, 32'h8);
        wr_reg(3'd3, 32'h0000_0008);
        rd_chk("R7 cleared", 3'd2, 32'h0);
        out_chk("R7 irq_out low", 1'b0);

        // R8 set wins over acknowledge on the same edge
        irq_src = 18'h00040;
        repeat (2) @(negedge clk);
        wr_reg(3'd3, 32'h0000_0040);
        rd_chk("R8 set wins", 3'd2, 32'h40);
        irq_src = '0;
        wr_reg(3'd3, 32'h0000_0040);
        rd_chk("R8 later clear", 3'd2, 32'h0);

        // R6 held line does not re-arm after acknowledge
        irq_src = 18'h00200;
        repeat (4) @(negedge clk);
        rd_chk("R6 held set", 3'd2, 32'h200);
        wr_reg(3'd3, 32'h0000_0200);
        repeat (3) @(negedge clk);
        rd_chk("R6 no re-arm", 3'd2, 32'h0);
        irq_src = '0;
        repeat (2) @(negedge clk);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule